// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Slave

This block is the serial front end of a small byte-wide memory that sits on an I2C bus as a slave. After a START it reads a device select byte. The select byte carries a fixed device code, the three strap bits and a direction bit. A write selection is followed by a two-byte memory address, high byte first. Data bytes then stream into the array or out of it. Every byte the slave receives is acknowledged on the ninth clock. Every byte the slave sends waits for the master's acknowledge on the ninth clock.

The block works on SCL and SDA levels that are already synchronised and oversampled by the system clock. It detects edges, START and STOP itself. It pulls SDA low through a single open-drain enable and never drives it high. The array is a synchronous RAM inside the block with 2**ADDR_W bytes; ADDR_W=13 gives the full 8K x 8 array. Writes finish within the bus cycle, so there is never a busy period. A write-protect input discards all array writes and leaves reads untouched. The pad supplies a weak pull-down on that pin, so an unconnected pin arrives here as low, with writes enabled.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the slave releases SDA (sda_oe_o=0) and stays idle until a START.
- R2: A select byte whose bits [7:4] equal 1010 and whose bits [3:1] equal strap_i[2:0] is acknowledged: SDA is held low while SCL is high on the 9th clock. Bit 0 is the direction: 0 means write, 1 means read.
- R3: A select byte with a wrong code or wrong strap bits gets no acknowledge. The slave then ignores all following bytes, and writes nothing, until the next START.
- R4: After a write selection the slave acknowledges two address bytes, high byte first. Only the low ADDR_W bits of the 16-bit value load the pointer.
- R5: Each write data byte is acknowledged and stored at the pointer. The pointer then steps by one and wraps from 2**ADDR_W-1 to 0.
- R6: A select with the direction bit at 1, including one after a repeated START, returns the byte at the current pointer. The byte goes out MSB first, with SDA changed only while SCL is low. SDA is released for the 9th clock. A master acknowledge (SDA low) fetches the next address.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START.
- R8: While wp_i is 1, data bytes are still acknowledged and the pointer still advances, but the array keeps its contents. Reads work for any wp_i level.
- R9: A selection that follows the STOP of a write at once is acknowledged, with no busy period.
- R10: sda_oe_o changes only in the cycle after SCL was seen low, and a START always leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level as seen on the wire |
| strap_i | input | 3 | Strap bits compared with select bits [3:1] |
| wp_i | input | 1 | Write protect, 1 blocks every array write |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
The bench builds the block with ADDR_W=13, the full 8K array, so a pointer at 0x1FFF wraps to 0x0000. With that width, the three upper bits of the high address byte are bits the block must drop. Strap bits are tied to 101, so a select byte differing only in the strap field can test the mismatch path. The bus runs with four system clocks per SCL phase. This leaves room between SCL edges for the edge detector and the one-cycle RAM read.

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int ADDR_W = 10,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);

  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_AH, ST_AL, ST_WR, ST_RD} st_t;

  st_t               st, nxt;
  logic              scl_q, sda_q, oe, ack_pend, mack;
  logic [3:0]        cnt;
  logic [7:0]        sh, ahi, rdq;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        mem [DEPTH];

  wire rise    = scl_i & ~scl_q;
  wire fall    = ~scl_i & scl_q;
  wire start_c = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c  = scl_i & scl_q & ~sda_q & sda_i;
  wire [7:0] byte_in = {sh[6:0], sda_i};
  wire sel_ok  = (byte_in[7:4] == DEV_CODE) && (byte_in[3:1] == strap_i);
  wire rx      = (st == ST_DEV) || (st == ST_AH) || (st == ST_AL) || (st == ST_WR);
  wire mem_we  = (st == ST_WR) && rise && (cnt == 4'd7) && !wp_i && !start_c && !stop_c;

  assign sda_oe_o = oe;

  always_ff @(posedge clk) begin
    if (mem_we) mem[ptr] <= byte_in;
    rdq <= mem[ptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; nxt <= ST_IDLE;
      scl_q <= 1'b1; sda_q <= 1'b1;
      oe <= 1'b0; ack_pend <= 1'b0; mack <= 1'b0;
      cnt <= '0; sh <= '0; ahi <= '0; ptr <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_c) begin
        st <= ST_DEV; cnt <= '0; oe <= 1'b0;
      end else if (stop_c) begin
        st <= ST_IDLE; cnt <= '0; oe <= 1'b0;
      end else if (rx) begin
        if (rise) begin
          if (cnt < 4'd8) sh <= byte_in;
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            ack_pend <= 1'b1;
            case (st)
              ST_DEV: begin
                ack_pend <= sel_ok;
                nxt <= !sel_ok ? ST_IDLE : (byte_in[0] ? ST_RD : ST_AH);
              end
              ST_AH: begin ahi <= byte_in; nxt <= ST_AL; end
              ST_AL: begin ptr <= ADDR_W'({ahi, byte_in}); nxt <= ST_WR; end
              default: begin ptr <= ptr + ADDR_W'(1); nxt <= ST_WR; end
            endcase
          end
        end else if (fall) begin
          if (cnt == 4'd8) oe <= ack_pend;
          else if (cnt == 4'd9) begin
            cnt <= '0;
            st  <= nxt;
            if (nxt == ST_RD) begin sh <= rdq; oe <= ~rdq[7]; end
            else oe <= 1'b0;
          end
        end
      end else if (st == ST_RD) begin
        if (rise) begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd8) mack <= ~sda_i;
        end else if (fall) begin
          if (cnt == 4'd8) begin
            oe  <= 1'b0;
            ptr <= ptr + ADDR_W'(1);
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            if (mack) begin sh <= rdq; oe <= ~rdq[7]; end
            else begin st <= ST_IDLE; oe <= 1'b0; end
          end else if (cnt != 4'd0) begin
            sh <= {sh[6:0], 1'b0};
            oe <= ~sh[6];
          end
        end
      end
    end
  end

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe != $past(oe)) |-> !$past(scl_i));

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !oe);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !oe);

  // R2
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && rx) |-> (cnt >= 4'd8));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR && $past(st) == ST_WR && ptr != $past(ptr)) |-> (ptr == ADDR_W'($past(ptr) + 1)));

endmodule

// File: tb/sim_i2c_mem_slave.sv
module sim_i2c_mem_slave;
  localparam int AW = 13;
  localparam int HP = 4;
  localparam logic [7:0] DW = 8'hAA;
  localparam logic [7:0] DR = 8'hAB;

  logic clk = 0, rst_n = 0, scl = 1, m_low = 0, wp = 0;
  logic [2:0] strap = 3'b101;
  wire sda_oe;
  wire sda_bus = ~(m_low | sda_oe);

  always #4 clk = ~clk;

  i2c_mem_slave #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(strap), .wp_i(wp), .sda_oe_o(sda_oe));

  int errors = 0, checks = 0, viol = 0;
  logic oe_p = 0, scl_p = 1;

  always @(posedge clk) begin
    if (rst_n && sda_oe !== oe_p && scl_p) viol++;
    oe_p = sda_oe;
    scl_p = scl;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 0; hold(HP); scl = 1; hold(HP); m_low = 1; hold(HP); scl = 0; hold(HP);
  endtask

  task automatic bus_stop();
    m_low = 1; hold(HP); scl = 1; hold(HP); m_low = 0; hold(2 * HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hold(HP); scl = 1; hold(HP); scl = 0; hold(1);
    end
    m_low = 0; hold(HP); scl = 1; hold(HP / 2);
    ack = ~sda_bus;
    hold(HP / 2); scl = 0; hold(HP);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      hold(HP); scl = 1; hold(HP / 2); d[i] = sda_bus; hold(HP / 2); scl = 0;
    end
    hold(1); m_low = give_ack; hold(HP); scl = 1; hold(HP); scl = 0; hold(1); m_low = 0; hold(HP);
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
    logic a;
    bus_start();
    send_byte(DW, a); chk({req, " select ack"}, a, 1);
    send_byte(hi, a); chk("R4 high address ack", a, 1);
    send_byte(lo, a); chk("R4 low address ack", a, 1);
  endtask

  task automatic t_reset();
    hold(5);
    chk("R1 sda released in reset", sda_oe, 0);
    rst_n = 1; hold(10);
    chk("R1 sda released after reset", sda_oe, 0);
  endtask

  task automatic t_write_seq();
    logic a;
    set_addr(8'hE0, 8'h10, "R2");
    send_byte(8'h11, a); chk("R5 data ack 0", a, 1);
    send_byte(8'h22, a); chk("R5 data ack 1", a, 1);
    send_byte(8'h33, a); chk("R5 data ack 2", a, 1);
    bus_stop();
  endtask

  task automatic t_read_back();
    logic a; logic [7:0] d;
    set_addr(8'h00, 8'h10, "R2");
    bus_start();
    send_byte(DR, a); chk("R6 read select ack", a, 1);
    recv_byte(1, d); chk("R6 read byte 0 (R4 upper bits dropped)", d, 8'h11);
    recv_byte(1, d); chk("R6 read byte 1", d, 8'h22);
    recv_byte(0, d); chk("R6 read byte 2", d, 8'h33);
    a = 0;
    for (int i = 0; i < 3; i++) begin
      hold(HP); scl = 1; if (sda_oe) a = 1; hold(HP); scl = 0; if (sda_oe) a = 1;
    end
    hold(HP); if (sda_oe) a = 1;
    chk("R7 no drive after master nak", a, 0);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] d;
    set_addr(8'hFF, 8'hFF, "R2");
    send_byte(8'hA5, a); chk("R5 ack at top address", a, 1);
    send_byte(8'h5A, a); chk("R5 ack after wrap", a, 1);
    bus_stop();
    bus_start();
    send_byte(DW, a); chk("R9 select right after write acked", a, 1);
    send_byte(8'h1F, a); send_byte(8'hFF, a);
    bus_start();
    send_byte(DR, a); chk("R6 read select after repeated start", a, 1);
    recv_byte(1, d); chk("R5 byte at top address", d, 8'hA5);
    recv_byte(0, d); chk("R5 byte at address 0 after wrap", d, 8'h5A);
    bus_stop();
  endtask

  task automatic t_wrong_dev();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'hA8, a); chk("R3 wrong strap select nak", a, 0);
    send_byte(8'h00, a); chk("R3 ignored address byte", a, 0);
    send_byte(8'h10, a); chk("R3 ignored address byte", a, 0);
    send_byte(8'h99, a); chk("R3 ignored data byte", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hBA, a); chk("R3 wrong code select nak", a, 0);
    bus_stop();
    set_addr(8'h00, 8'h10, "R3");
    bus_start();
    send_byte(DR, a);
    recv_byte(0, d); chk("R3 array unchanged", d, 8'h11);
    bus_stop();
  endtask

  task automatic t_protect();
    logic a; logic [7:0] d;
    wp = 1;
    set_addr(8'h00, 8'h10, "R8");
    send_byte(8'h77, a); chk("R8 protected byte acked", a, 1);
    send_byte(8'h88, a); chk("R8 protected byte acked", a, 1);
    bus_stop();
    bus_start();
    send_byte(DR, a); chk("R8 read select with wp high", a, 1);
    recv_byte(0, d); chk("R8 pointer advanced past discarded bytes", d, 8'h33);
    bus_stop();
    set_addr(8'h00, 8'h10, "R8");
    bus_start();
    send_byte(DR, a);
    recv_byte(1, d); chk("R8 protected location 0 kept", d, 8'h11);
    recv_byte(0, d); chk("R8 protected location 1 kept", d, 8'h22);
    bus_stop();
    wp = 0;
  endtask

  initial begin
    bit timeout = 0;
    fork
      begin
        t_reset();
        t_write_seq();
        t_read_back();
        t_wrap();
        t_wrong_dev();
        t_protect();
        hold(10);
      end
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    chk("R10 sda changes only while scl low", viol, 0);
    if (timeout) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule